// File: doc/BRIEF.md
# OUT Endpoint Receive Controller

This block receives data for a single bulk or interrupt OUT endpoint. On one side it takes a simplified packet stream: a one-cycle token pulse that opens a transaction aimed at this endpoint, data bytes qualified by a valid strobe, and an end-of-packet pulse that carries a CRC-good flag. On the other side it offers a local register view. That view is a receive byte count, a FIFO-empty flag, an enable bit, an ACK status flag and an interrupt. Received bytes are read out through a data port, one byte per read strobe.

Whether a transaction is accepted is decided once, on the token cycle, from the enable bit. An accepted transaction that ends cleanly is answered with an ACK code. An ACK also clears the enable by hardware. Software then drains the bytes and re-arms the endpoint by pulsing a write-one set input, so every packet needs its own permission. A transaction that arrives while the endpoint is disarmed stores nothing and is answered with NAK. An accepted packet that overruns the FIFO, or that ends with a bad CRC, is dropped without a handshake. In that case the endpoint stays armed for the host's retry.

Top module: `usb_out_rx`

## Requirements
- R1: After reset the enable, interrupt and ACK flag are 0, the receive count is 0, the empty flag is 1 and no handshake strobe is issued.
- R2: A one-cycle pulse on `sw_set_en` sets the enable from the next cycle. While the input is held at 0 the enable does not change.
- R3: If the enable is 1 on the token cycle, each following valid byte is stored. A good-CRC end-of-packet then yields `hs_valid` high for exactly the one cycle after the end-of-packet cycle, with `hs_code` = 2'b01 (ACK).
- R4: If the enable is 0 on the token cycle, no byte is stored and the count is unchanged. A good-CRC end-of-packet yields `hs_code` = 2'b10 (NAK).
- R5: An ACK clears the enable in the same cycle that the strobe rises, and sets both `irq` and `ack_flag`. `irq_clr` clears only `irq`, and `stat_clr` clears only `ack_flag`.
- R6: `rx_count` equals the number of bytes held, from 0 up to the depth. `fifo_empty` is 1 exactly when the count is 0.
- R7: `rd_data` shows the oldest held byte. Each `sw_rd` pulse advances to the next byte in arrival order and lowers the count by one. A read while the count is 0 changes nothing.
- R8: In an accepted transaction, a byte that arrives while the FIFO is full marks the packet as overrun. At end-of-packet the FIFO is then flushed (count 0), `hs_code` = 2'b00 (none) is strobed, and the enable stays 1.
- R9: An end-of-packet with a bad CRC strobes `hs_code` = 2'b00. If the transaction was accepted, the FIFO is flushed and the enable stays 1.
- R10: The accept decision holds for the whole transaction, so setting the enable mid-packet still gives NAK. An accepted transaction always starts from an empty FIFO, which discards any unread bytes.
- R11: `hs_code` never takes the value 2'b11 while `hs_valid` is high, and `hs_valid` is never high on two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_token | input | 1 | One-cycle pulse: OUT transaction to this endpoint begins |
| pkt_valid | input | 1 | `pkt_byte` holds a payload byte |
| pkt_byte | input | 8 | Payload byte |
| pkt_eop | input | 1 | One-cycle pulse: end of data packet |
| pkt_crc_ok | input | 1 | CRC result, qualified by `pkt_eop` |
| hs_valid | output | 1 | One-cycle handshake strobe |
| hs_code | output | 2 | 00 none, 01 ACK, 10 NAK |
| sw_set_en | input | 1 | Write-one pulse that arms the endpoint |
| sw_rd | input | 1 | Read strobe: pop one byte |
| irq_clr | input | 1 | Clears the interrupt |
| stat_clr | input | 1 | Clears the ACK status flag |
| rd_data | output | 8 | Oldest byte held in the FIFO |
| rx_count | output | $clog2(DEPTH+1) | Number of bytes held |
| fifo_empty | output | 1 | FIFO holds no byte |
| ep_en | output | 1 | Endpoint armed for reception |
| ack_flag | output | 1 | Last accepted transaction was ACKed |
| irq | output | 1 | Endpoint interrupt |

## Verification
The assertions assume the following about the packet side. Token, byte-valid and end-of-packet never coincide, and end-of-packet only follows a token. They also assume that software does not pulse the set input on an end-of-packet cycle, and that it reads only between transactions. The drain property relies on the last of these. The bench drives every packet through one task that opens with a lone token, sends bytes on separate cycles and closes with a lone end-of-packet. Register-side pulses are issued only between packets, except in the single mid-packet arming case, which lands on a byte cycle.

// File: rtl/oep_pkg.sv
package oep_pkg;
   typedef enum logic [1:0] {
      HS_NONE = 2'b00,
      HS_ACK  = 2'b01,
      HS_NAK  = 2'b10
   } hs_e;
endpackage

// File: rtl/oep_fifo.sv
module oep_fifo #(
   parameter int DEPTH = 64,
   parameter int WIDTH = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         flush,
   input  logic                         wr,
   input  logic [WIDTH-1:0]             wdata,
   input  logic                         rd,
   output logic [WIDTH-1:0]             rdata,
   output logic [$clog2(DEPTH+1)-1:0]   count,
   output logic                         full,
   output logic                         empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH+1);

   initial assert (DEPTH >= 2) else $error("oep_fifo: DEPTH must be at least 2");

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wptr, rptr, wnext, rnext;
   logic             do_wr, do_rd;

   assign full  = (count == CW'(DEPTH));
   assign empty = (count == '0);
   assign do_wr = wr & ~full;
   assign do_rd = rd & ~empty;
   assign rdata = mem[rptr];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wnext = wptr + 1'b1;
         assign rnext = rptr + 1'b1;
      end else begin : g_wrap
         assign wnext = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
         assign rnext = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_wr && !flush) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else if (flush) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_wr) wptr <= wnext;
         if (do_rd) rptr <= rnext;
         count <= count + CW'(do_wr) - CW'(do_rd);
      end
   end
endmodule

// File: rtl/oep_txn.sv
module oep_txn
   import oep_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic pkt_token,
   input  logic pkt_valid,
   input  logic pkt_eop,
   input  logic pkt_crc_ok,
   input  logic en,
   input  logic fifo_full,
   output logic fifo_wr,
   output logic fifo_flush,
   output logic ack_evt,
   output logic hs_valid,
   output hs_e  hs_code
);
   logic active, acc_q, ovf_q, eop_evt;

   assign eop_evt    = active & pkt_eop & ~pkt_token;
   assign ack_evt    = eop_evt & acc_q & pkt_crc_ok & ~ovf_q;
   assign fifo_wr    = active & acc_q & pkt_valid & ~pkt_eop & ~pkt_token;
   assign fifo_flush = (pkt_token & en) | (eop_evt & acc_q & ~ack_evt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         acc_q    <= 1'b0;
         ovf_q    <= 1'b0;
         hs_valid <= 1'b0;
         hs_code  <= HS_NONE;
      end else begin
         hs_valid <= 1'b0;
         hs_code  <= HS_NONE;
         if (pkt_token) begin
            active <= 1'b1;
            acc_q  <= en;
            ovf_q  <= 1'b0;
         end else if (eop_evt) begin
            active   <= 1'b0;
            hs_valid <= 1'b1;
            if (ack_evt)
               hs_code <= HS_ACK;
            else if (!acc_q && pkt_crc_ok)
               hs_code <= HS_NAK;
         end else if (fifo_wr && fifo_full) begin
            ovf_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/oep_flags.sv
module oep_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic set_en,
   input  logic ack_evt,
   input  logic irq_clr,
   input  logic stat_clr,
   output logic en,
   output logic irq,
   output logic ack_flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en       <= 1'b0;
         irq      <= 1'b0;
         ack_flag <= 1'b0;
      end else begin
         if (ack_evt)     en <= 1'b0;
         else if (set_en) en <= 1'b1;
         if (ack_evt)      irq <= 1'b1;
         else if (irq_clr) irq <= 1'b0;
         if (ack_evt)       ack_flag <= 1'b1;
         else if (stat_clr) ack_flag <= 1'b0;
      end
   end
endmodule

// File: rtl/usb_out_rx.sv
module usb_out_rx
   import oep_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int DW    = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        pkt_token,
   input  logic                        pkt_valid,
   input  logic [DW-1:0]               pkt_byte,
   input  logic                        pkt_eop,
   input  logic                        pkt_crc_ok,
   output logic                        hs_valid,
   output logic [1:0]                  hs_code,
   input  logic                        sw_set_en,
   input  logic                        sw_rd,
   input  logic                        irq_clr,
   input  logic                        stat_clr,
   output logic [DW-1:0]               rd_data,
   output logic [$clog2(DEPTH+1)-1:0]  rx_count,
   output logic                        fifo_empty,
   output logic                        ep_en,
   output logic                        ack_flag,
   output logic                        irq
);
   initial assert (DW >= 1) else $error("usb_out_rx: DW must be positive");

   logic fifo_wr, fifo_flush, fifo_full, ack_evt;
   hs_e  hs_code_e;

   assign hs_code = hs_code_e;

   oep_txn u_txn (
      .clk        (clk),
      .rst_n      (rst_n),
      .pkt_token  (pkt_token),
      .pkt_valid  (pkt_valid),
      .pkt_eop    (pkt_eop),
      .pkt_crc_ok (pkt_crc_ok),
      .en         (ep_en),
      .fifo_full  (fifo_full),
      .fifo_wr    (fifo_wr),
      .fifo_flush (fifo_flush),
      .ack_evt    (ack_evt),
      .hs_valid   (hs_valid),
      .hs_code    (hs_code_e)
   );

   oep_fifo #(.DEPTH(DEPTH), .WIDTH(DW)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (fifo_flush),
      .wr    (fifo_wr),
      .wdata (pkt_byte),
      .rd    (sw_rd),
      .rdata (rd_data),
      .count (rx_count),
      .full  (fifo_full),
      .empty (fifo_empty)
   );

   oep_flags u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (sw_set_en),
      .ack_evt  (ack_evt),
      .irq_clr  (irq_clr),
      .stat_clr (stat_clr),
      .en       (ep_en),
      .irq      (irq),
      .ack_flag (ack_flag)
   );
endmodule

// File: rtl/usb_out_rx_chk.sv
module usb_out_rx_chk #(
   parameter int DEPTH = 64
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        pkt_token,
   input logic                        pkt_valid,
   input logic                        pkt_eop,
   input logic                        sw_set_en,
   input logic                        sw_rd,
   input logic                        hs_valid,
   input logic [1:0]                  hs_code,
   input logic [$clog2(DEPTH+1)-1:0]  rx_count,
   input logic                        fifo_empty,
   input logic                        ep_en,
   input logic                        irq,
   input logic                        ack_flag
);
   p_set_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sw_set_en && !pkt_eop |=> ep_en);

   p_ack_disarms_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hs_valid && hs_code == 2'b01 |-> !ep_en && irq && ack_flag);

   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_count <= ($clog2(DEPTH+1))'(DEPTH));

   p_empty_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_empty == (rx_count == '0));

   p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rd && rx_count != '0 && !pkt_token && !pkt_valid && !pkt_eop
      |=> rx_count == $past(rx_count) - 1'b1);

   p_discard_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hs_valid && hs_code == 2'b00 && ep_en |-> rx_count == '0);

   p_code_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
      hs_valid |-> hs_code != 2'b11);

   p_strobe_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      hs_valid |=> !hs_valid);
endmodule

bind usb_out_rx usb_out_rx_chk #(.DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pkt_token  (pkt_token),
   .pkt_valid  (pkt_valid),
   .pkt_eop    (pkt_eop),
   .sw_set_en  (sw_set_en),
   .sw_rd      (sw_rd),
   .hs_valid   (hs_valid),
   .hs_code    (hs_code),
   .rx_count   (rx_count),
   .fifo_empty (fifo_empty),
   .ep_en      (ep_en),
   .irq        (irq),
   .ack_flag   (ack_flag)
);

// File: tb/test_usb_out_rx.sv
module test_usb_out_rx;
   localparam int DEPTH = 8;
   localparam int CW = $clog2(DEPTH+1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pkt_token = 0, pkt_valid = 0, pkt_eop = 0, pkt_crc_ok = 0;
   logic [7:0] pkt_byte = '0;
   logic sw_set_en = 0, sw_rd = 0, irq_clr = 0, stat_clr = 0;
   logic hs_valid, fifo_empty, ep_en, ack_flag, irq;
   logic [1:0] hs_code;
   logic [7:0] rd_data;
   logic [CW-1:0] rx_count;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   usb_out_rx #(.DEPTH(DEPTH), .DW(8)) i_usb_out_rx (
      .clk(clk), .rst_n(rst_n), .pkt_token(pkt_token), .pkt_valid(pkt_valid),
      .pkt_byte(pkt_byte), .pkt_eop(pkt_eop), .pkt_crc_ok(pkt_crc_ok),
      .hs_valid(hs_valid), .hs_code(hs_code), .sw_set_en(sw_set_en), .sw_rd(sw_rd),
      .irq_clr(irq_clr), .stat_clr(stat_clr), .rd_data(rd_data), .rx_count(rx_count),
      .fifo_empty(fifo_empty), .ep_en(ep_en), .ack_flag(ack_flag), .irq(irq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int base, input int i);
      return 8'((base + i * 37) & 8'hff);
   endfunction

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic pulse_set();
      sw_set_en = 1; tick(); sw_set_en = 0;
   endtask

   // token, n bytes, eop; returns sampled strobe/code in the cycle after eop
   task automatic send(input int n, input bit crc, input int base, input bit arm_mid,
                       output logic hv, output logic [1:0] hc);
      pkt_token = 1; tick(); pkt_token = 0;
      for (int i = 0; i < n; i++) begin
         pkt_valid = 1; pkt_byte = pat(base, i);
         if (arm_mid && i == 0) sw_set_en = 1;
         tick();
         sw_set_en = 0;
      end
      pkt_valid = 0;
      pkt_eop = 1; pkt_crc_ok = crc; tick();
      pkt_eop = 0; pkt_crc_ok = 0;
      hv = hs_valid; hc = hs_code;
      tick();
      chk(hs_valid == 0, "R11 strobe one cycle", hs_valid, 0);
   endtask

   task automatic drain(input int n, input int base);
      for (int i = 0; i < n; i++) begin
         chk(rd_data == pat(base, i), "R7 read order", rd_data, pat(base, i));
         chk(rx_count == CW'(n - i), "R7 count before read", rx_count, n - i);
         sw_rd = 1; tick(); sw_rd = 0;
      end
      chk(rx_count == 0, "R7 count after drain", rx_count, 0);
      sw_rd = 1; tick(); sw_rd = 0;
      chk(rx_count == 0 && fifo_empty, "R7 read at empty ignored", rx_count, 0);
   endtask

   initial begin
      logic hv;
      logic [1:0] hc;
      tick(); tick();
      // R1 reset state
      chk(ep_en == 0 && irq == 0 && ack_flag == 0, "R1 flags at reset", {ep_en, irq, ack_flag}, 0);
      chk(rx_count == 0 && fifo_empty == 1 && hs_valid == 0, "R1 fifo at reset", rx_count, 0);
      rst_n = 1; tick();

      // R2 idle keeps enable low
      tick(); tick();
      chk(ep_en == 0, "R2 no pulse no arm", ep_en, 0);

      // R4 disarmed transaction -> NAK, nothing stored
      send(3, 1, 5, 0, hv, hc);
      chk(hv == 1 && hc == 2'b10, "R4 NAK code", hc, 2);
      chk(rx_count == 0, "R4 nothing stored", rx_count, 0);
      // R9 disarmed, bad CRC -> none
      send(2, 0, 5, 0, hv, hc);
      chk(hv == 1 && hc == 2'b00, "R9 bad CRC no handshake", hc, 0);

      // R2 arm
      pulse_set();
      chk(ep_en == 1, "R2 set pulse arms", ep_en, 1);

      // R3/R5/R6/R7 sweep lengths 0..DEPTH
      for (int n = 0; n <= DEPTH; n++) begin
         if (!ep_en) pulse_set();
         send(n, 1, n * 11, 0, hv, hc);
         chk(hv == 1 && hc == 2'b01, "R3 ACK code", hc, 1);
         chk(ep_en == 0, "R5 ACK disarms", ep_en, 0);
         chk(irq == 1 && ack_flag == 1, "R5 irq and flag set", {irq, ack_flag}, 3);
         chk(rx_count == CW'(n), "R6 count equals length", rx_count, n);
         chk(fifo_empty == (n == 0), "R6 empty flag", fifo_empty, n == 0);
         drain(n, n * 11);
         irq_clr = 1; tick(); irq_clr = 0;
         chk(irq == 0 && ack_flag == 1, "R5 irq_clr only irq", {irq, ack_flag}, 1);
         stat_clr = 1; tick(); stat_clr = 0;
         chk(ack_flag == 0, "R5 stat_clr clears flag", ack_flag, 0);
      end

      // R8 overrun
      for (int n = DEPTH + 1; n <= DEPTH + 3; n++) begin
         pulse_set();
         send(n, 1, 3, 0, hv, hc);
         chk(hv == 1 && hc == 2'b00, "R8 overrun no handshake", hc, 0);
         chk(rx_count == 0, "R8 flushed", rx_count, 0);
         chk(ep_en == 1, "R8 stays armed", ep_en, 1);
      end

      // R9 accepted bad CRC at all lengths
      for (int n = 1; n <= DEPTH; n++) begin
         send(n, 0, 9, 0, hv, hc);
         chk(hv == 1 && hc == 2'b00, "R9 bad CRC code", hc, 0);
         chk(rx_count == 0 && ep_en == 1, "R9 flushed and armed", rx_count, 0);
      end

      // R10 arming mid-packet still NAKs
      send(1, 1, 0, 0, hv, hc);   // consume arm with an ACK
      drain(1, 0);
      chk(ep_en == 0, "R10 disarmed before test", ep_en, 0);
      send(4, 1, 20, 1, hv, hc);
      chk(hv == 1 && hc == 2'b10, "R10 mid arm still NAK", hc, 2);
      chk(rx_count == 0 && ep_en == 1, "R10 armed after NAK", rx_count, 0);
      send(2, 1, 30, 0, hv, hc);
      chk(hc == 2'b01, "R10 next txn accepted", hc, 1);
      // R10 accepted transaction starts empty
      pulse_set();
      send(3, 1, 40, 0, hv, hc);
      chk(hc == 2'b01 && rx_count == 3, "R10 old bytes discarded", rx_count, 3);
      drain(3, 40);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule